// File: doc/BRIEF.md
# Block-Erase Byte-Program Memory Controller

This block is a byte-wide non-volatile-style memory with flash rules. Reads work like an ordinary RAM: strobe a read and the byte shows up on the data output one cycle later. Writes have two restrictions. A byte can be programmed only while it still holds its erased value, which is all ones. Bytes return to that value only when the whole block that holds them is erased. A block is a parameterised power-of-two group of consecutive bytes.

Programming keeps the block busy for `PROG_CYC` cycles. A block erase keeps it busy for the much longer `ERASE_CYC` cycles. Each block has a counter of accepted erases. Once a block's counter reaches `WEAR_MAX`, further erase requests for that block are refused and the worn flag pulses.

The controller has four states:
- **IDLE** accepts commands.
- **PROG** counts down the program time and commits the byte in its last cycle.
- **ERASE_HOLD** covers the early part of an erase.
- **ERASE_WIPE** fills the block with ones, one byte per cycle, during the final block-size cycles.

It has these transitions:
- IDLE→PROG on an accepted program.
- PROG→IDLE when the timer is exhausted.
- IDLE→ERASE_HOLD on an accepted erase.
- ERASE_HOLD→ERASE_WIPE when the remaining time equals the block size.
- ERASE_WIPE→IDLE when the timer is exhausted.

Top module: `blkflash_ctrl`

## Requirements
- R1: After reset, busy, err and worn are 0, rdata is 0, and every byte reads 8'hFF.
- R2: A read strobe while idle puts the byte at addr on rdata after the next clock edge. Otherwise rdata holds its value.
- R3: A program strobe while idle, to a byte reading 8'hFF, raises busy for exactly PROG_CYC cycles starting the cycle after the strobe. The byte then reads back as wdata.
- R4: A program strobe while idle, to a byte not reading 8'hFF, pulses err in the next cycle, leaves busy low and leaves the byte unchanged.
- R5: An accepted erase raises busy for exactly ERASE_CYC cycles. Afterwards every byte of the addressed block reads 8'hFF and bytes of other blocks are unchanged.
- R6: Any strobe while busy is ignored and pulses err in the next cycle.
- R7: Two or more strobes in the same cycle while idle are ignored (no busy, no contents change, rdata held) and pulse err in the next cycle.
- R8: Each accepted erase increments the block's counter. An erase to a block whose counter equals WEAR_MAX is refused: worn pulses in the next cycle, busy stays low, contents are kept, and other blocks still erase.
- R9: The block index is addr[ADDR_W-1:BLK_W] and the byte offset is addr[BLK_W-1:0]. Erasing one block never touches the last byte of the block below it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Byte address for all commands |
| wdata | input | DATA_W | Byte to program |
| rd_req | input | 1 | Read strobe |
| prog_req | input | 1 | Program strobe |
| erase_req | input | 1 | Block erase strobe (any address inside the block) |
| rdata | output | DATA_W | Registered read data |
| busy | output | 1 | High for the whole program or erase |
| err | output | 1 | One-cycle pulse for a rejected or ignored command |
| worn | output | 1 | One-cycle pulse for an erase refused at the wear limit |

## Verification
A command table walks the read, program and erase paths over erased and programmed bytes. It separates an accepted first program from a refused overwrite, and an erased block from an untouched neighbour. Directed patterns cover the remaining cases:
- Strobes arriving mid-erase show that busy blocks commands rather than queueing them.
- Colliding strobes show that the collision is rejected as a whole, with no single command chosen.
- Repeated erases of one block up to the wear limit show that refusal is counted per block.
- An erase next to a programmed block edge shows that the block index is decoded from the upper address bits.

// File: rtl/blkflash_pkg.sv
package blkflash_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PROG,
        ST_ERASE_HOLD,
        ST_ERASE_WIPE
    } fl_state_e;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_READ,
        CMD_PROG,
        CMD_ERASE,
        CMD_CLASH
    } fl_cmd_e;

endpackage

// File: rtl/blkflash_decode.sv
module blkflash_decode
    import blkflash_pkg::*;
(
    input  logic    rd_req,
    input  logic    prog_req,
    input  logic    erase_req,
    output fl_cmd_e cmd
);
    always_comb begin
        unique case ({rd_req, prog_req, erase_req})
            3'b000:  cmd = CMD_NONE;
            3'b100:  cmd = CMD_READ;
            3'b010:  cmd = CMD_PROG;
            3'b001:  cmd = CMD_ERASE;
            default: cmd = CMD_CLASH;
        endcase
    end
endmodule

// File: rtl/blkflash_array.sv
module blkflash_array #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rbyte,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wbyte
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells[i] <= '1;
            end
        end else if (we) begin
            cells[waddr] <= wbyte;
        end
    end

    assign rbyte = cells[raddr];
endmodule

// File: rtl/blkflash_wear.sv
module blkflash_wear #(
    parameter int IDX_W    = 4,
    parameter int WEAR_MAX = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] sel,
    input  logic             inc,
    output logic             at_limit
);
    localparam int NUM_BLK = 1 << IDX_W;
    localparam int WEAR_W  = $clog2(WEAR_MAX + 1);

    logic [WEAR_W-1:0] erase_cnt [NUM_BLK];
    logic [WEAR_W-1:0] sel_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < NUM_BLK; b++) begin
                erase_cnt[b] <= '0;
            end
        end else if (inc) begin
            erase_cnt[sel] <= erase_cnt[sel] + 1'b1;
        end
    end

    assign sel_cnt  = erase_cnt[sel];
    assign at_limit = (sel_cnt == WEAR_W'(WEAR_MAX));

    // An accepted erase is only ever counted while the block has headroom.
    assert_wear_headroom_R8: assert property (@(posedge clk) disable iff (!rst_n)
        inc |-> (sel_cnt < WEAR_W'(WEAR_MAX)));
endmodule

// File: rtl/blkflash_timer.sv
module blkflash_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] remain
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (load) begin
            remain <= load_val;
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end
endmodule

// File: rtl/blkflash_ctrl.sv
module blkflash_ctrl
    import blkflash_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 8,
    parameter int BLK_W     = 4,
    parameter int PROG_CYC  = 6,
    parameter int ERASE_CYC = 64,
    parameter int WEAR_MAX  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd_req,
    input  logic              prog_req,
    input  logic              erase_req,
    output logic [DATA_W-1:0] rdata,
    output logic              busy,
    output logic              err,
    output logic              worn
);
    localparam int BLK_BYTES = 1 << BLK_W;
    localparam int IDX_W     = ADDR_W - BLK_W;
    localparam int TMR_W     = $clog2(ERASE_CYC + 1);

    fl_state_e         state, state_nxt;
    fl_cmd_e           cmd;
    logic [DATA_W-1:0] cell_now;
    logic              cell_erased;
    logic              wear_full;
    logic [TMR_W-1:0]  remain;

    logic              tmr_load;
    logic [TMR_W-1:0]  tmr_val;
    logic              lat_en;
    logic              rd_take;
    logic              err_set;
    logic              worn_set;
    logic              wear_inc;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [DATA_W-1:0] mem_wbyte;

    logic [ADDR_W-1:0] lat_addr;
    logic [DATA_W-1:0] lat_data;
    logic [DATA_W-1:0] rdata_q;
    logic              err_q;
    logic              worn_q;

    blkflash_decode u_decode (
        .rd_req    (rd_req),
        .prog_req  (prog_req),
        .erase_req (erase_req),
        .cmd       (cmd)
    );

    blkflash_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .raddr (addr),
        .rbyte (cell_now),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wbyte (mem_wbyte)
    );

    blkflash_wear #(.IDX_W(IDX_W), .WEAR_MAX(WEAR_MAX)) u_wear (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (addr[ADDR_W-1:BLK_W]),
        .inc      (wear_inc),
        .at_limit (wear_full)
    );

    blkflash_timer #(.W(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .remain   (remain)
    );

    assign cell_erased = (cell_now == '1);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // next state and datapath control
    always_comb begin
        state_nxt = state;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        lat_en    = 1'b0;
        rd_take   = 1'b0;
        err_set   = 1'b0;
        worn_set  = 1'b0;
        wear_inc  = 1'b0;
        mem_we    = 1'b0;
        mem_waddr = lat_addr;
        mem_wbyte = lat_data;
        unique case (state)
            ST_IDLE: begin
                unique case (cmd)
                    CMD_NONE:  ;
                    CMD_READ:  rd_take = 1'b1;
                    CMD_PROG: begin
                        if (cell_erased) begin
                            state_nxt = ST_PROG;
                            tmr_load  = 1'b1;
                            tmr_val   = TMR_W'(PROG_CYC - 1);
                            lat_en    = 1'b1;
                        end else begin
                            err_set = 1'b1;
                        end
                    end
                    CMD_ERASE: begin
                        if (wear_full) begin
                            worn_set = 1'b1;
                        end else begin
                            state_nxt = ST_ERASE_HOLD;
                            tmr_load  = 1'b1;
                            tmr_val   = TMR_W'(ERASE_CYC - 1);
                            lat_en    = 1'b1;
                            wear_inc  = 1'b1;
                        end
                    end
                    CMD_CLASH: err_set = 1'b1;
                    default:   err_set = 1'b1;
                endcase
            end
            ST_PROG: begin
                err_set = (cmd != CMD_NONE);
                if (remain == '0) begin
                    mem_we    = 1'b1;
                    state_nxt = ST_IDLE;
                end
            end
            ST_ERASE_HOLD: begin
                err_set = (cmd != CMD_NONE);
                if (remain == TMR_W'(BLK_BYTES)) state_nxt = ST_ERASE_WIPE;
            end
            ST_ERASE_WIPE: begin
                err_set   = (cmd != CMD_NONE);
                mem_we    = 1'b1;
                mem_waddr = {lat_addr[ADDR_W-1:BLK_W], remain[BLK_W-1:0]};
                mem_wbyte = '1;
                if (remain == '0) state_nxt = ST_IDLE;
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_addr <= '0;
            lat_data <= '0;
            rdata_q  <= '0;
            err_q    <= 1'b0;
            worn_q   <= 1'b0;
        end else begin
            if (lat_en) begin
                lat_addr <= addr;
                lat_data <= wdata;
            end
            if (rd_take) rdata_q <= cell_now;
            err_q  <= err_set;
            worn_q <= worn_set;
        end
    end

    // outputs
    always_comb begin
        busy  = (state != ST_IDLE);
        err   = err_q;
        worn  = worn_q;
        rdata = rdata_q;
    end

    assert_prog_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd == CMD_PROG && cell_erased) |=> busy);

    assert_prog_reject_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && prog_req && !rd_req && !erase_req && !cell_erased) |=> (err && !busy));

    assert_busy_ignore_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (rd_req || prog_req || erase_req)) |=> err);

    assert_clash_reject_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $countones({rd_req, prog_req, erase_req}) > 1) |=> (err && !busy && $stable(rdata)));

    assert_worn_refuse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && erase_req && !rd_req && !prog_req && wear_full) |=> (worn && !busy));
endmodule

// File: tb/blkflash_ctrl_tb.sv
module blkflash_ctrl_tb;
    localparam int ADDR_W    = 8;
    localparam int DATA_W    = 8;
    localparam int BLK_W     = 4;
    localparam int PROG_CYC  = 6;
    localparam int ERASE_CYC = 64;
    localparam int WEAR_MAX  = 3;

    typedef struct packed {
        logic [1:0] op;      // 0 read, 1 program, 2 erase
        logic [7:0] a;
        logic [7:0] d;
        logic       exp_err;
        logic [7:0] exp_rd;
    } vec_t;

    localparam int NVEC = 15;
    localparam vec_t VECS [NVEC] = '{
        '{2'd0, 8'h00, 8'h00, 1'b0, 8'hFF},
        '{2'd1, 8'h00, 8'hA5, 1'b0, 8'h00},
        '{2'd0, 8'h00, 8'h00, 1'b0, 8'hA5},
        '{2'd1, 8'h00, 8'h5A, 1'b1, 8'h00},
        '{2'd0, 8'h00, 8'h00, 1'b0, 8'hA5},
        '{2'd1, 8'h01, 8'h00, 1'b0, 8'h00},
        '{2'd1, 8'h10, 8'h3C, 1'b0, 8'h00},
        '{2'd0, 8'h01, 8'h00, 1'b0, 8'h00},
        '{2'd2, 8'h05, 8'h00, 1'b0, 8'h00},
        '{2'd0, 8'h00, 8'h00, 1'b0, 8'hFF},
        '{2'd0, 8'h01, 8'h00, 1'b0, 8'hFF},
        '{2'd0, 8'h10, 8'h00, 1'b0, 8'h3C},
        '{2'd1, 8'h00, 8'h77, 1'b0, 8'h00},
        '{2'd0, 8'h00, 8'h00, 1'b0, 8'h77},
        '{2'd0, 8'hFF, 8'h00, 1'b0, 8'hFF}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] wdata = '0;
    logic              rd_req = 1'b0;
    logic              prog_req = 1'b0;
    logic              erase_req = 1'b0;
    logic [DATA_W-1:0] rdata;
    logic              busy;
    logic              err;
    logic              worn;

    int nchk = 0;
    int nerr = 0;

    always #5 clk = ~clk;

    blkflash_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLK_W(BLK_W),
        .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC), .WEAR_MAX(WEAR_MAX)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
        .rd_req(rd_req), .prog_req(prog_req), .erase_req(erase_req),
        .rdata(rdata), .busy(busy), .err(err), .worn(worn)
    );

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [1:0] op, input logic [7:0] a, input logic [7:0] d,
                         output logic e, output logic w, output int bc);
        @(negedge clk);
        addr = a; wdata = d;
        rd_req = (op == 2'd0); prog_req = (op == 2'd1); erase_req = (op == 2'd2);
        @(negedge clk);
        rd_req = 1'b0; prog_req = 1'b0; erase_req = 1'b0;
        e = err; w = worn; bc = 0;
        while (busy) begin
            bc++;
            @(negedge clk);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] v);
        logic e, w;
        int bc;
        issue(2'd0, a, 8'h00, e, w, bc);
        v = rdata;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nerr++; nchk++;
        $display("FAIL watchdog R1-all actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        logic e, w;
        int bc;
        logic [7:0] v;
        int bad;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", busy, 0);
        chk("R1 err", err, 0);
        chk("R1 worn", worn, 0);
        chk("R1 rdata", rdata, 0);
        bad = 0;
        for (int i = 0; i < (1 << ADDR_W); i++) begin
            rd(8'(i), v);
            if (v != 8'hFF) bad++;
        end
        chk("R1 erased bytes not FF", bad, 0);

        // table: R2 R3 R4 R5
        for (int k = 0; k < NVEC; k++) begin
            int exp_bc;
            issue(VECS[k].op, VECS[k].a, VECS[k].d, e, w, bc);
            exp_bc = (VECS[k].op == 2'd1 && !VECS[k].exp_err) ? PROG_CYC :
                     (VECS[k].op == 2'd2) ? ERASE_CYC : 0;
            chk("R4 err pulse (table)", e, VECS[k].exp_err);
            chk("R3 R5 busy length (table)", bc, exp_bc);
            chk("R8 worn quiet (table)", w, 0);
            if (VECS[k].op == 2'd0) chk("R2 R5 read data (table)", rdata, VECS[k].exp_rd);
        end

        // R6: strobe during erase is ignored
        @(negedge clk);
        addr = 8'h20; erase_req = 1'b1;
        @(negedge clk);
        erase_req = 1'b0;
        chk("R5 busy after erase", busy, 1);
        addr = 8'h30; wdata = 8'h11; prog_req = 1'b1;
        @(negedge clk);
        prog_req = 1'b0;
        chk("R6 err during busy", err, 1);
        chk("R6 still busy", busy, 1);
        while (busy) @(negedge clk);
        rd(8'h30, v);
        chk("R6 ignored program", v, 8'hFF);

        // R7: collided strobes
        rd(8'h10, v);
        chk("R2 read before clash", v, 8'h3C);
        @(negedge clk);
        addr = 8'h40; wdata = 8'h12; rd_req = 1'b1; prog_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0; prog_req = 1'b0;
        chk("R7 err on clash", err, 1);
        chk("R7 no busy on clash", busy, 0);
        chk("R7 R2 rdata held", rdata, 8'h3C);
        rd(8'h40, v);
        chk("R7 byte untouched", v, 8'hFF);

        // R8: wear limit on block 5
        issue(2'd1, 8'h50, 8'h99, e, w, bc);
        for (int n = 0; n < WEAR_MAX; n++) begin
            issue(2'd2, 8'h55, 8'h00, e, w, bc);
            chk("R8 erase accepted under limit", bc, ERASE_CYC);
            chk("R8 worn quiet under limit", w, 0);
        end
        issue(2'd1, 8'h50, 8'h66, e, w, bc);
        chk("R3 program after erase", bc, PROG_CYC);
        issue(2'd2, 8'h50, 8'h00, e, w, bc);
        chk("R8 worn on limit", w, 1);
        chk("R8 no busy on limit", bc, 0);
        rd(8'h50, v);
        chk("R8 contents kept", v, 8'h66);
        issue(2'd2, 8'h60, 8'h00, e, w, bc);
        chk("R8 other block erases", bc, ERASE_CYC);
        chk("R8 other block not worn", w, 0);

        // R9: block boundary
        issue(2'd1, 8'h6F, 8'h21, e, w, bc);
        issue(2'd1, 8'h70, 8'h22, e, w, bc);
        issue(2'd2, 8'h7A, 8'h00, e, w, bc);
        rd(8'h6F, v);
        chk("R9 lower block kept", v, 8'h21);
        rd(8'h70, v);
        chk("R9 block start erased", v, 8'hFF);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule